// File: doc/BRIEF.md
# Transmit FIFO ECC Error Interrupt Controller

This block gathers error events from the transmit FIFOs of up to eight ports (four by default) and folds them into one level interrupt. Every port has a store-and-forward FIFO and a reorder FIFO. Each FIFO pulses a correctable and an uncorrectable error line. Each port also reports a reorder error and a packet-assembly-dead condition. The events are latched into a packed status register that holds one 6-bit field per port, with a matching mask register. Every FIFO also has its own ECC status word, which keeps the class of error seen until software clears it.

Software reaches all registers through a single-cycle request port. A write takes effect on the clock edge that accepts it. Read data comes back one cycle after the request, qualified by `rvalid_o`. Status bits are cleared by writing ones (write-one-to-clear). An ECC status word is cleared as a whole by writing a value with bit 31 set.

The interrupt output is driven by a two-state machine:
- **QUIET**: the output is low. The transition *raise* to RAISED is taken when any status bit is set while its mask bit is clear.
- **RAISED**: the output is high. The transition *drop* back to QUIET is taken once no unmasked status bit remains.

Top module: `ecc_irq_ctrl`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0x3f3f3f3f (all six bits of each of the four default ports set), every ECC status word reads 0, and `irq_o` is low.
- R2: A pulse on event bit `evt_i[6p+i]` sets status bit 8p+i, and that bit stays set without further pulses. The values of i are: 0 for store-and-forward correctable, 1 for store-and-forward uncorrectable, 2 for reorder correctable, 3 for reorder uncorrectable, 4 for reorder error, and 5 for packet-assembly-dead.
- R3: A write to the status register at address 0x000 clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: When an event arrives in the same cycle as a write-one-to-clear of its status bit, the bit stays set.
- R5: The mask register at address 0x008 takes the written value in bits 8p..8p+5. A mask bit of 1 keeps its status bit from raising the interrupt.
- R6: `irq_o` goes high one cycle after some status bit is set with its mask bit clear. It stays high while any such bit remains. It goes low one cycle after the last one is cleared or masked.
- R7: The ECC status word of the store-and-forward FIFO of port p sits at 0x400+0x100p, and that of the reorder FIFO at 0x800+0x100p. In each word, bit 17 records a correctable error and bit 16 records an uncorrectable error.
- R8: A write with bit 31 set clears the whole ECC status word it addresses, and a write with bit 31 clear leaves it unchanged. An event in the same cycle as the clear is still recorded.
- R9: Read data is valid, with `rvalid_o` high, exactly one cycle after a read request. Reserved bit positions and unmapped addresses read as 0.
- R10: Clearing an ECC status word leaves the port's status field unchanged, and clearing status bits leaves the ECC status words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6*NPORT | Error event pulses, 6 per port |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address: bank in the top 2 bits, port in the bits above bit 7 |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default NPORT of 4. This gives a 12-bit address whose bits 9:8 select the port. It covers the highest field (bits 24..29), the port-3 ECC words, and the unused fourth bank at 0xC00. A scoreboard checks the reads and in-line checks follow the interrupt level. Together they exercise event/clear collisions on both the packed status field and an ECC status word, masking a pending source off, and writes of ones into reserved mask bits.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;

    localparam int FLD_W       = 6;
    localparam int FLD_STRIDE  = 8;
    localparam int REG_W       = 64;
    localparam int PORT_LG     = 8;
    localparam int CE_BIT      = 17;
    localparam int UE_BIT      = 16;
    localparam int CLR_BIT     = 31;
    localparam int OFS_STAT    = 0;
    localparam int OFS_MASK    = 8;

    localparam int EV_SF_CE    = 0;
    localparam int EV_SF_UE    = 1;
    localparam int EV_RO_CE    = 2;
    localparam int EV_RO_UE    = 3;

    typedef enum logic [1:0] {
        BANK_GLB  = 2'd0,
        BANK_SF   = 2'd1,
        BANK_RO   = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic ce;
        logic ue;
    } ecc_st_t;

    function automatic logic [REG_W-1:0] ecc_word(input ecc_st_t s);
        logic [REG_W-1:0] w;
        w         = '0;
        w[CE_BIT] = s.ce;
        w[UE_BIT] = s.ue;
        return w;
    endfunction

endpackage

// File: rtl/ecc_port_stat.sv
module ecc_port_stat
    import ecc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] evt_i,
    input  logic [FLD_W-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [FLD_W-1:0] mask_wd_i,
    input  logic             sf_clr_i,
    input  logic             ro_clr_i,
    output logic [FLD_W-1:0] stat_o,
    output logic [FLD_W-1:0] mask_o,
    output ecc_st_t          sf_o,
    output ecc_st_t          ro_o
);

    logic [FLD_W-1:0] stat_q, mask_q;
    ecc_st_t          sf_q, ro_q, sf_new, ro_new;

    always_comb begin
        sf_new = '{ce: evt_i[EV_SF_CE], ue: evt_i[EV_SF_UE]};
        ro_new = '{ce: evt_i[EV_RO_CE], ue: evt_i[EV_RO_UE]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
            sf_q   <= '0;
            ro_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | evt_i;
            if (mask_we_i) begin
                mask_q <= mask_wd_i;
            end
            sf_q <= (sf_clr_i ? ecc_st_t'('0) : sf_q) | sf_new;
            ro_q <= (ro_clr_i ? ecc_st_t'('0) : ro_q) | ro_new;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign sf_o   = sf_q;
    assign ro_o   = ro_q;

endmodule

// File: rtl/ecc_irq_fsm.sv
module ecc_irq_fsm
    import ecc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_i) state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/ecc_reg_rd.sv
module ecc_reg_rd
    import ecc_irq_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  bank_e             bank_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              psel_ok_i,
    input  logic [7:0]        low_i,
    input  logic [REG_W-1:0]  stat_i,
    input  logic [REG_W-1:0]  mask_i,
    input  ecc_st_t           sf_i [NPORT],
    input  ecc_st_t           ro_i [NPORT],
    output logic [REG_W-1:0]  rdata_o,
    output logic              rvalid_o
);

    logic [REG_W-1:0] rd_d;
    logic             glb_sel;

    assign glb_sel = (psel_i == '0);

    always_comb begin
        rd_d = '0;
        unique case (bank_i)
            BANK_GLB: begin
                if (glb_sel && low_i == 8'(OFS_STAT)) rd_d = stat_i;
                if (glb_sel && low_i == 8'(OFS_MASK)) rd_d = mask_i;
            end
            BANK_SF: begin
                if (psel_ok_i && low_i == 8'd0) rd_d = ecc_word(sf_i[psel_i]);
            end
            BANK_RO: begin
                if (psel_ok_i && low_i == 8'd0) rd_d = ecc_word(ro_i[psel_i]);
            end
            BANK_NONE: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en_i;
            if (rd_en_i) begin
                rdata_o <= rd_d;
            end
        end
    end

endmodule

// File: rtl/ecc_irq_ctrl.sv
module ecc_irq_ctrl
    import ecc_irq_pkg::*;
#(
    parameter  int NPORT    = 4,
    localparam int PSEL_W   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int BANK_LSB = PORT_LG + PSEL_W,
    localparam int ADDR_W   = BANK_LSB + 2,
    localparam int EVT_W    = NPORT * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              rvalid_o,
    output logic              irq_o
);

    bank_e             bank;
    logic [PSEL_W-1:0] psel;
    logic [7:0]        low;
    logic              psel_ok, glb_sel, wr;
    logic              wr_stat, wr_mask, wr_sf, wr_ro;
    logic [REG_W-1:0]  stat_all, mask_all;
    logic              pend;

    logic [FLD_W-1:0]  stat_v [NPORT];
    logic [FLD_W-1:0]  mask_v [NPORT];
    ecc_st_t           sf_v   [NPORT];
    ecc_st_t           ro_v   [NPORT];

    assign bank    = bank_e'(addr_i[ADDR_W-1:BANK_LSB]);
    assign psel    = addr_i[BANK_LSB-1:PORT_LG];
    assign low     = addr_i[PORT_LG-1:0];
    assign psel_ok = ({1'b0, psel} < (PSEL_W+1)'(NPORT));
    assign glb_sel = (bank == BANK_GLB) && (psel == '0);
    assign wr      = req_i && we_i;
    assign wr_stat = wr && glb_sel && (low == 8'(OFS_STAT));
    assign wr_mask = wr && glb_sel && (low == 8'(OFS_MASK));
    assign wr_sf   = wr && (bank == BANK_SF) && (low == 8'd0) && wdata_i[CLR_BIT];
    assign wr_ro   = wr && (bank == BANK_RO) && (low == 8'd0) && wdata_i[CLR_BIT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [FLD_W-1:0] clr_p;
        assign clr_p = wr_stat ? wdata_i[p*FLD_STRIDE +: FLD_W] : '0;

        ecc_port_stat u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[p*FLD_W +: FLD_W]),
            .clr_i     (clr_p),
            .mask_we_i (wr_mask),
            .mask_wd_i (wdata_i[p*FLD_STRIDE +: FLD_W]),
            .sf_clr_i  (wr_sf && (psel == PSEL_W'(p))),
            .ro_clr_i  (wr_ro && (psel == PSEL_W'(p))),
            .stat_o    (stat_v[p]),
            .mask_o    (mask_v[p]),
            .sf_o      (sf_v[p]),
            .ro_o      (ro_v[p])
        );
    end

    always_comb begin
        stat_all = '0;
        mask_all = '0;
        for (int p = 0; p < NPORT; p++) begin
            stat_all[p*FLD_STRIDE +: FLD_W] = stat_v[p];
            mask_all[p*FLD_STRIDE +: FLD_W] = mask_v[p];
        end
    end

    assign pend = |(stat_all & ~mask_all);

    ecc_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .irq_o  (irq_o)
    );

    ecc_reg_rd #(
        .NPORT  (NPORT),
        .PSEL_W (PSEL_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (req_i && !we_i),
        .bank_i    (bank),
        .psel_i    (psel),
        .psel_ok_i (psel_ok),
        .low_i     (low),
        .stat_i    (stat_all),
        .mask_i    (mask_all),
        .sf_i      (sf_v),
        .ro_i      (ro_v),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

endmodule

// File: rtl/ecc_irq_ctrl_chk.sv
module ecc_irq_ctrl_chk
    import ecc_irq_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPORT*FLD_W-1:0] evt_i,
    input logic                   req_i,
    input logic                   we_i,
    input logic [ADDR_W-1:0]      addr_i,
    input logic                   rvalid_o,
    input logic                   irq_o,
    input logic [REG_W-1:0]       stat_all,
    input logic [REG_W-1:0]       mask_all
);

    logic [REG_W-1:0] evt_map;
    logic             is_rd, stat_wr, mask_wr, pend;

    always_comb begin
        evt_map = '0;
        for (int p = 0; p < NPORT; p++) begin
            evt_map[p*FLD_STRIDE +: FLD_W] = evt_i[p*FLD_W +: FLD_W];
        end
    end

    assign is_rd   = req_i && !we_i;
    assign stat_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_STAT));
    assign mask_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_MASK));
    assign pend    = |(stat_all & ~mask_all);

    // R2
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_map) |=> ((stat_all & $past(evt_map)) == $past(evt_map)));

    // R3
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_all) & ~stat_all)) |-> $past(stat_wr));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_all));

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pend));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && pend) |=> irq_o);

    // R9
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rvalid_o);

    // R9
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rvalid_o);

endmodule

bind ecc_irq_ctrl ecc_irq_ctrl_chk #(
    .NPORT  (NPORT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .rvalid_o (rvalid_o),
    .irq_o    (irq_o),
    .stat_all (stat_all),
    .mask_all (mask_all)
);

// File: tb/ecc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_irq_ctrl_tb;

    localparam int NP = 4;
    localparam int AW = 12;
    localparam logic [63:0] FM = 64'h3f3f3f3f;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [23:0]   evt = '0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          rvalid;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_stat = '0;
    logic [63:0] m_mask = FM;
    logic [1:0]  m_sf [NP];
    logic [1:0]  m_ro [NP];

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    ecc_irq_ctrl #(.NPORT(NP)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .irq_o    (irq)
    );

    function automatic logic [63:0] eccw(input logic [1:0] v);
        return {46'b0, v, 16'b0};
    endfunction

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9: unexpected rvalid, got 1 expected 0");
            end else begin
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic apply_model(input logic w, input logic [AW-1:0] a,
                               input logic [63:0] d, input logic [23:0] e);
        if (w) begin
            if (a == 12'h000) m_stat = m_stat & ~(d & FM);
            else if (a == 12'h008) m_mask = d & FM;
            else if (a[11:10] == 2'd1 && a[7:0] == 8'd0 && d[31]) m_sf[a[9:8]] = 2'b00;
            else if (a[11:10] == 2'd2 && a[7:0] == 8'd0 && d[31]) m_ro[a[9:8]] = 2'b00;
        end
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < 6; i++) m_stat[8*p+i] = m_stat[8*p+i] | e[6*p+i];
            m_sf[p] = m_sf[p] | {e[6*p+0], e[6*p+1]};
            m_ro[p] = m_ro[p] | {e[6*p+2], e[6*p+3]};
        end
    endtask

    task automatic cyc(input logic [23:0] e, input logic w,
                       input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        evt = e; req = w; we = w; addr = a; wdata = d;
        @(negedge clk);
        evt = '0; req = 1'b0; we = 1'b0;
        apply_model(w, a, d, e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [63:0] e, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        chk({63'b0, irq}, {63'b0, |(m_stat & ~m_mask)}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_sf[p] = 2'b00;
            m_ro[p] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk({63'b0, irq}, 64'd0, "R1 irq after reset");
        rd(12'h000, 64'd0, "R1 status after reset");
        rd(12'h008, FM, "R1 mask after reset");
        rd(12'h400, 64'd0, "R1 sf0 after reset");
        rd(12'hB00, 64'd0, "R1 ro3 after reset");

        // R2 event while masked; R5 masking keeps irq low
        cyc(24'h000040, 1'b0, '0, '0);
        rd(12'h000, m_stat, "R2 port1 sf ce sticky");
        chk_irq("R5 masked source no irq");

        // R5 unmask port1, R6 raise
        cyc('0, 1'b1, 12'h008, 64'h3f3f003f);
        chk_irq("R6 irq raised after unmask");
        rd(12'h008, m_mask, "R5 mask readback");
        cyc('0, 1'b1, 12'h008, 64'hffff_ffff_ffff_ffff);
        rd(12'h008, m_mask, "R9 reserved mask bits read zero");
        cyc('0, 1'b1, 12'h008, 64'h3f3f003f);

        // R2 all bits of port3 plus port0 reorder uncorrectable
        cyc(24'hfc0008, 1'b0, '0, '0);
        rd(12'h000, m_stat, "R2 port3 full field and port0 ro ue");
        // R7 ECC words
        rd(12'h700, eccw(m_sf[3]), "R7 sf3 ce and ue");
        rd(12'hB00, eccw(m_ro[3]), "R7 ro3 ce and ue");
        rd(12'h800, eccw(m_ro[0]), "R7 ro0 ue only");
        rd(12'h500, eccw(m_sf[1]), "R7 sf1 ce only");

        // R3 partial W1C, R6 drop, R10 ECC word untouched
        cyc('0, 1'b1, 12'h000, 64'h0000_0100);
        rd(12'h000, m_stat, "R3 w1c clears bit8 only");
        chk_irq("R6 irq dropped after clear");
        rd(12'h500, eccw(m_sf[1]), "R10 sf1 kept after status clear");

        // R4 event wins over W1C of the same bit
        cyc(24'h000100, 1'b1, 12'h000, 64'h0000_0400);
        rd(12'h000, m_stat, "R4 event beats w1c");
        chk_irq("R6 irq raised by port1 ro ce");

        // R8 ECC clear needs bit31
        cyc('0, 1'b1, 12'h500, 64'h0002_0000);
        rd(12'h500, eccw(m_sf[1]), "R8 write without bit31 ignored");
        cyc('0, 1'b1, 12'h500, 64'h8000_0000);
        rd(12'h500, 64'd0, "R8 bulk clear sf1");
        rd(12'h000, m_stat, "R10 status kept after ecc clear");
        cyc(24'h200000, 1'b1, 12'hB00, 64'h8000_0000);
        rd(12'hB00, 64'h0001_0000, "R8 event beats ecc clear");

        // R9 unmapped addresses
        rd(12'hC00, 64'd0, "R9 unused bank reads zero");
        rd(12'h010, 64'd0, "R9 unmapped global offset");
        rd(12'h404, 64'd0, "R9 unmapped sf offset");
        rd(12'h108, 64'd0, "R9 global bank port field nonzero");

        // R6 masking a pending source drops irq
        cyc('0, 1'b1, 12'h008, 64'h3f3f3f3f);
        chk_irq("R6 irq dropped by mask");
        cyc('0, 1'b1, 12'h008, 64'h3f3f0000);
        chk_irq("R6 irq raised again on unmask");

        // R3 clear everything
        cyc('0, 1'b1, 12'h000, 64'hffff_ffff_ffff_ffff);
        rd(12'h000, 64'd0, "R3 full w1c");
        chk_irq("R6 irq low after full clear");

        repeat (3) @(negedge clk);
        chk(64'(exp_q.size()), 64'd0, "R9 all reads answered");
        finish_run();
    end

endmodule